// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block sits beside the instruction fetch unit and guesses, in the same cycle as the fetch, where the next fetch should go. It holds a direct-mapped table of recently resolved branches. Each slot keeps a valid flag, the upper address bits of the branch that owns it, the address that branch jumped to when it was last taken, and a two-bit saturating confidence counter. When the fetch address matches a valid slot, the counter's upper bit gives the direction. A taken guess steers fetch to the stored target, and a not-taken guess lets fetch run on sequentially.

When the fetch address is not in the table, a fixed rule based on branch direction is used. The decoder says whether the branch points backward and supplies the target it computed. A backward branch is guessed taken toward that decoded target. A forward branch is guessed not taken. The lookup result also carries a hit flag, so that later stages can see which source made the guess.

When a branch resolves in the execute stage, the resolution port trains the table. If the resolved address still owns its slot, that slot's counter moves one step toward the actual outcome. Otherwise the slot is claimed for the branch and seeded with a weak counter, overwriting whatever it held before.

Top module: `btb_predictor`

## Requirements
- R1: After reset every slot is invalid, so every lookup reports `predHit` = 0 until a resolution has been written.
- R2: On a lookup miss with `fetchValid` = 1, `predTaken` equals `fetchBackward`. A backward miss drives `predNextAddr` = `fetchDecodeTarget`. A forward miss drives `fetchAddr` + 4.
- R3: On a hit, counter values 2'b10 and 2'b11 give `predTaken` = 1 with `predNextAddr` set to the stored target. Values 2'b00 and 2'b01 give `predTaken` = 0 with `predNextAddr` = `fetchAddr` + 4. The hit result takes priority over `fetchBackward`.
- R4: A taken resolution on an owned slot adds one to its counter, and the counter holds at 2'b11. A not-taken resolution subtracts one, and the counter holds at 2'b00.
- R5: A resolution whose address does not own its slot claims that slot. The slot's counter is seeded with 2'b10 if the branch was taken and 2'b01 if it was not. A taken claim also stores `resTarget`. A lookup of that address in the cycle after the update edge hits.
- R6: The slot index is address bits [9:2] (256 slots, 4-byte alignment) and the tag is bits [31:10]. Two addresses with the same index and different tags alias: only the most recently claimed one hits.
- R7: A taken resolution on an owned slot rewrites the stored target with `resTarget`. A not-taken resolution leaves the stored target unchanged.
- R8: When a lookup and a resolution touch the same slot in one cycle, the lookup reports the slot as it was before that cycle's update. The update becomes visible from the next cycle.
- R9: While `fetchValid` = 0, `predHit` and `predTaken` are 0 and `predNextAddr` = `fetchAddr` + 4.
- R10: Table contents change only on a clock edge where `resValid` = 1. A repeated lookup with no resolution in between returns the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset, clears all valid flags |
| fetchValid | input | 1 | A lookup is requested this cycle |
| fetchAddr | input | 32 | Address of the instruction being fetched |
| fetchBackward | input | 1 | Decoder flag: the branch target lies below the branch |
| fetchDecodeTarget | input | 32 | Target computed by the decoder, used on a backward miss |
| predHit | output | 1 | The lookup matched a valid slot |
| predTaken | output | 1 | Predicted direction |
| predNextAddr | output | 32 | Predicted next fetch address |
| resValid | input | 1 | A branch resolved this cycle |
| resAddr | input | 32 | Address of the resolved branch |
| resTaken | input | 1 | Actual outcome of the resolved branch |
| resTarget | input | 32 | Actual target of the resolved branch when taken |

## Verification
A lookup and a resolution can land on the same slot in one cycle. The bench provokes this by presenting the fetch address and the resolution of that same address at one falling edge. It first does this on a slot that is already trained, which flips the direction from taken to not taken. It then does it on an empty slot that gets claimed in that cycle. In both cases the outputs are sampled before the rising edge and expected to show the old state. They are sampled again one cycle later and expected to show the new counter or the new hit.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr_e;

  // Strobes from control into the table datapath
  typedef struct packed {
    logic wrEn;      // write the indexed slot at the next edge
    logic allocate;  // claim the slot (new tag, seeded counter)
    logic outcome;   // resolved direction
  } btbStrobe_t;

  function automatic ctr_e ctrStep(ctr_e cur, logic taken);
    ctr_e nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_STRONG_T) nxt = ctr_e'(cur + 2'b01);
    end else begin
      if (cur != CTR_STRONG_NT) nxt = ctr_e'(cur - 2'b01);
    end
    return nxt;
  endfunction

  function automatic ctr_e ctrSeed(logic taken);
    return taken ? CTR_WEAK_T : CTR_WEAK_NT;
  endfunction

endpackage

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  lookIdx,
  output logic              lookValid,
  output logic [TAG_W-1:0]  lookTag,
  output logic [ADDR_W-1:0] lookTarget,
  output ctr_e              lookCtr,
  input  logic [IDX_W-1:0]  resIdx,
  input  logic [TAG_W-1:0]  resTag,
  input  logic [ADDR_W-1:0] resTarget,
  input  btbStrobe_t        strobe,
  output logic              resEntryValid,
  output logic [TAG_W-1:0]  resEntryTag
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ [ENTRIES];
  logic [ADDR_W-1:0]  tgtQ [ENTRIES];
  ctr_e               ctrQ [ENTRIES];
  ctr_e               nextCtr;

  // Read ports are combinational: a same-cycle write is seen next cycle
  assign lookValid     = validQ[lookIdx];
  assign lookTag       = tagQ[lookIdx];
  assign lookTarget    = tgtQ[lookIdx];
  assign lookCtr       = ctrQ[lookIdx];
  assign resEntryValid = validQ[resIdx];
  assign resEntryTag   = tagQ[resIdx];

  always_comb begin
    if (strobe.allocate) nextCtr = ctrSeed(strobe.outcome);
    else                 nextCtr = ctrStep(ctrQ[resIdx], strobe.outcome);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            validQ <= '0;
    else if (strobe.wrEn) validQ[resIdx] <= 1'b1;
  end

  // Payload fields need no reset: guarded by validQ
  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      ctrQ[resIdx] <= nextCtr;
      if (strobe.allocate) tagQ[resIdx] <= resTag;
      if (strobe.outcome)  tgtQ[resIdx] <= resTarget;
    end
  end

endmodule

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 8,
  parameter int TAG_W   = 22,
  parameter int ALIGN_W = 2
) (
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchBackward,
  input  logic [ADDR_W-1:0] fetchDecodeTarget,
  output logic              predHit,
  output logic              predTaken,
  output logic [ADDR_W-1:0] predNextAddr,
  input  logic              resValid,
  input  logic [ADDR_W-1:0] resAddr,
  input  logic              resTaken,
  output logic [IDX_W-1:0]  lookIdx,
  input  logic              lookValid,
  input  logic [TAG_W-1:0]  lookTag,
  input  logic [ADDR_W-1:0] lookTarget,
  input  ctr_e              lookCtr,
  output logic [IDX_W-1:0]  resIdx,
  output logic [TAG_W-1:0]  resTag,
  input  logic              resEntryValid,
  input  logic [TAG_W-1:0]  resEntryTag,
  output btbStrobe_t        strobe
);

  localparam int INSN_BYTES = 1 << ALIGN_W;

  logic [TAG_W-1:0]  fetchTag;
  logic [ADDR_W-1:0] seqAddr;
  logic              lookMatch;
  logic              resOwned;

  assign lookIdx  = fetchAddr[ALIGN_W +: IDX_W];
  assign fetchTag = fetchAddr[ADDR_W-1 -: TAG_W];
  assign resIdx   = resAddr[ALIGN_W +: IDX_W];
  assign resTag   = resAddr[ADDR_W-1 -: TAG_W];
  assign seqAddr  = fetchAddr + ADDR_W'(INSN_BYTES);

  generate
    if (ALIGN_W > 0) begin : g_lowBits
      logic unusedLowBits;
      assign unusedLowBits = ^{fetchAddr[ALIGN_W-1:0], resAddr[ALIGN_W-1:0]};
    end
  endgenerate

  // Lookup and prediction select
  assign lookMatch = lookValid && (lookTag == fetchTag);

  always_comb begin
    predHit      = 1'b0;
    predTaken    = 1'b0;
    predNextAddr = seqAddr;
    if (fetchValid) begin
      if (lookMatch) begin
        predHit   = 1'b1;
        predTaken = lookCtr[1];
        if (lookCtr[1]) predNextAddr = lookTarget;
      end else begin
        predTaken = fetchBackward;
        if (fetchBackward) predNextAddr = fetchDecodeTarget;
      end
    end
  end

  // Resolution: train an owned slot or claim it
  assign resOwned = resEntryValid && (resEntryTag == resTag);

  always_comb begin
    strobe          = '0;
    strobe.wrEn     = resValid;
    strobe.allocate = resValid && !resOwned;
    strobe.outcome  = resTaken;
  end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 256,
  parameter int ALIGN_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchBackward,
  input  logic [ADDR_W-1:0] fetchDecodeTarget,
  output logic              predHit,
  output logic              predTaken,
  output logic [ADDR_W-1:0] predNextAddr,
  input  logic              resValid,
  input  logic [ADDR_W-1:0] resAddr,
  input  logic              resTaken,
  input  logic [ADDR_W-1:0] resTarget
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - ALIGN_W;

  logic [IDX_W-1:0]  lookIdx;
  logic              lookValid;
  logic [TAG_W-1:0]  lookTag;
  logic [ADDR_W-1:0] lookTarget;
  ctr_e              lookCtr;
  logic [IDX_W-1:0]  resIdx;
  logic [TAG_W-1:0]  resTag;
  logic              resEntryValid;
  logic [TAG_W-1:0]  resEntryTag;
  btbStrobe_t        strobe;

  btb_ctrl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .ALIGN_W(ALIGN_W)
  ) u_ctrl (
    .fetchValid       (fetchValid),
    .fetchAddr        (fetchAddr),
    .fetchBackward    (fetchBackward),
    .fetchDecodeTarget(fetchDecodeTarget),
    .predHit          (predHit),
    .predTaken        (predTaken),
    .predNextAddr     (predNextAddr),
    .resValid         (resValid),
    .resAddr          (resAddr),
    .resTaken         (resTaken),
    .lookIdx          (lookIdx),
    .lookValid        (lookValid),
    .lookTag          (lookTag),
    .lookTarget       (lookTarget),
    .lookCtr          (lookCtr),
    .resIdx           (resIdx),
    .resTag           (resTag),
    .resEntryValid    (resEntryValid),
    .resEntryTag      (resEntryTag),
    .strobe           (strobe)
  );

  btb_datapath #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .lookIdx      (lookIdx),
    .lookValid    (lookValid),
    .lookTag      (lookTag),
    .lookTarget   (lookTarget),
    .lookCtr      (lookCtr),
    .resIdx       (resIdx),
    .resTag       (resTag),
    .resTarget    (resTarget),
    .strobe       (strobe),
    .resEntryValid(resEntryValid),
    .resEntryTag  (resEntryTag)
  );

endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int ADDR_W  = 32,
  parameter int ALIGN_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              fetchValid,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              fetchBackward,
  input logic [ADDR_W-1:0] fetchDecodeTarget,
  input logic              predHit,
  input logic              predTaken,
  input logic [ADDR_W-1:0] predNextAddr,
  input logic              resValid,
  input logic [ADDR_W-1:0] resAddr,
  input logic              resTaken,
  input logic [ADDR_W-1:0] resTarget
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << ALIGN_W);

  logic anyWrite;
  logic unusedChk;
  assign unusedChk = ^{resTaken, resTarget};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         anyWrite <= 1'b0;
    else if (resValid) anyWrite <= 1'b1;
  end

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !anyWrite |-> !predHit); // R1

  AST_MISS_STATIC_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !predHit) |-> (predTaken == fetchBackward)); // R2

  AST_MISS_BACK_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !predHit && fetchBackward) |-> (predNextAddr == fetchDecodeTarget)); // R2

  AST_NOT_TAKEN_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    !predTaken |-> (predNextAddr == fetchAddr + STEP)); // R3

  AST_CLAIM_THEN_HIT: assert property (@(posedge clk) disable iff (!rstN)
    resValid ##1 (fetchValid && fetchAddr == $past(resAddr)) |-> predHit); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |-> (!predHit && !predTaken)); // R9

  AST_HOLD_WITHOUT_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !resValid) ##1 (fetchValid && $stable(fetchAddr) &&
      $stable(fetchBackward) && $stable(fetchDecodeTarget))
    |-> ($stable(predHit) && $stable(predTaken) && $stable(predNextAddr))); // R10

endmodule

bind btb_predictor btb_checker #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) u_chk (.*);

// File: tb/tb_btb_predictor.sv
module tb_btb_predictor;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        fetchBackward = 1'b0;
  logic [31:0] fetchDecodeTarget = '0;
  logic        predHit;
  logic        predTaken;
  logic [31:0] predNextAddr;
  logic        resValid = 1'b0;
  logic [31:0] resAddr = '0;
  logic        resTaken = 1'b0;
  logic [31:0] resTarget = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  btb_predictor dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic setFetch(logic v, logic [31:0] a, logic back, logic [31:0] dt);
    fetchValid = v; fetchAddr = a; fetchBackward = back; fetchDecodeTarget = dt;
  endtask

  task automatic expectOut(string req, logic eh, logic et, logic [31:0] en);
    chk({req, " hit"}, 32'(predHit), 32'(eh));
    chk({req, " taken"}, 32'(predTaken), 32'(et));
    chk({req, " next"}, predNextAddr, en);
  endtask

  task automatic look(string req, logic v, logic [31:0] a, logic back, logic [31:0] dt,
                      logic eh, logic et, logic [31:0] en);
    @(negedge clk);
    setFetch(v, a, back, dt);
    #2;
    expectOut(req, eh, et, en);
  endtask

  task automatic resolve(logic [31:0] a, logic t, logic [31:0] tg);
    @(negedge clk);
    resValid = 1'b1; resAddr = a; resTaken = t; resTarget = tg;
    @(negedge clk);
    resValid = 1'b0;
  endtask

  localparam logic [31:0] A = 32'h0000_1000, TA = 32'h0000_0800;
  localparam logic [31:0] B = 32'h0000_2004, TB = 32'h0000_2100;
  localparam logic [31:0] C = 32'h0000_2404, TC = 32'h0000_2500, TC2 = 32'h0000_2600;
  localparam logic [31:0] D = 32'h0000_3008, TD = 32'h0000_3100;
  localparam logic [31:0] E = 32'h0000_400C, TE = 32'h0000_4200;

  task automatic t_reset_and_static;
    look("R1 R2 forward miss", 1, A, 0, 32'h0F00, 0, 0, A + 4);
    look("R1 R2 backward miss", 1, A, 1, 32'h0F00, 0, 1, 32'h0F00);
    look("R1 other slot miss", 1, D, 0, 32'h0, 0, 0, D + 4);
  endtask

  task automatic t_counter_walk;
    resolve(A, 0, TA);                       // claim, seed 01
    look("R5 seed weak not-taken", 1, A, 1, 32'h0F00, 1, 0, A + 4);
    look("R10 repeat lookup", 1, A, 1, 32'h0F00, 1, 0, A + 4);
    resolve(A, 1, TA);                       // 10
    look("R4 R3 up to weak taken", 1, A, 0, 32'h0, 1, 1, TA);
    resolve(A, 1, TA);                       // 11
    resolve(A, 1, TA);                       // stays 11
    resolve(A, 0, TA);                       // 10
    look("R4 ceiling holds", 1, A, 0, 32'h0, 1, 1, TA);
    resolve(A, 0, TA);                       // 01
    look("R4 down to weak not-taken", 1, A, 0, 32'h0, 1, 0, A + 4);
    resolve(A, 0, TA);                       // 00
    resolve(A, 0, TA);                       // stays 00
    resolve(A, 1, TA);                       // 01
    look("R4 floor holds", 1, A, 1, 32'h0F00, 1, 0, A + 4);
  endtask

  task automatic t_taken_claim;
    resolve(B, 1, TB);                       // claim, seed 10
    look("R5 seed weak taken", 1, B, 0, 32'h0, 1, 1, TB);
    resolve(B, 0, TB);                       // 01
    look("R5 weak taken flips once", 1, B, 0, 32'h0, 1, 0, B + 4);
  endtask

  task automatic t_alias;
    look("R6 alias misses", 1, C, 0, 32'h0, 0, 0, C + 4);
    resolve(C, 1, TC);                       // overwrite slot 1
    look("R6 evicted owner misses", 1, B, 0, 32'h0, 0, 0, B + 4);
    look("R6 new owner hits", 1, C, 0, 32'h0, 1, 1, TC);
  endtask

  task automatic t_target_rewrite;
    resolve(C, 1, TC2);                      // 11, target TC2
    look("R7 taken rewrites target", 1, C, 0, 32'h0, 1, 1, TC2);
    resolve(C, 0, 32'h9999_0000);            // 10, target kept
    look("R7 not-taken keeps target", 1, C, 0, 32'h0, 1, 1, TC2);
  endtask

  task automatic t_same_cycle;
    resolve(D, 1, TD);                       // 10
    @(negedge clk);
    setFetch(1, D, 0, 32'h0);
    resValid = 1'b1; resAddr = D; resTaken = 1'b0; resTarget = TD;
    #2;
    expectOut("R8 old counter visible", 1, 1, TD);
    @(negedge clk);
    resValid = 1'b0;
    #2;
    expectOut("R8 new counter next cycle", 1, 0, D + 4);
    @(negedge clk);
    setFetch(1, E, 0, 32'h0);
    resValid = 1'b1; resAddr = E; resTaken = 1'b1; resTarget = TE;
    #2;
    expectOut("R8 claim not yet visible", 0, 0, E + 4);
    @(negedge clk);
    resValid = 1'b0;
    #2;
    expectOut("R8 R5 claim visible next cycle", 1, 1, TE);
  endtask

  task automatic t_idle;
    look("R9 idle at taken slot", 0, C, 1, 32'h1234_0000, 0, 0, C + 4);
    look("R9 resume after idle", 1, C, 0, 32'h0, 1, 1, TC2);
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset_and_static();
    t_counter_walk();
    t_taken_claim();
    t_alias();
    t_target_rewrite();
    t_same_cycle();
    t_idle();
    repeat (2) @(negedge clk);
    finishRun();
  end

  initial begin
    #(20 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

endmodule